// File: doc/BRIEF.md
# Prescaled 16-bit Down-Counter Timer

This block is a memory-mapped interval timer. A 16-bit counter counts down by one on each tick of a prescaler. The prescaler divides an enable-qualified system clock by 1, 16 or 256. Software writes a start value, selects a mode and a divider in a control word, and then reads the live count over a simple 32-bit register bus. Each time the count expires at zero, an expiry flag is set. The flag drives an interrupt line through a mask bit, and software drops it by writing a dedicated clear address.

There are two modes:

- **Free-running:** the counter rolls from zero to 0xFFFF.
- **Periodic:** the counter reloads the programmed start value at zero.

With the nominal 24 MHz input and the divide-by-256 setting, the count moves at 93.75 kHz.

The operating state machine has three named states:

- `ST_IDLE`: halted.
- `ST_FREE`: counting, rolling over to all ones.
- `ST_PERIOD`: counting, reloading from the load register.

Every transition is taken on a write to the control address, and any state can reach any other:

- **IDLE→FREE / IDLE→PERIOD:** enable bit set, with the mode bit selecting which.
- **FREE↔PERIOD:** enable bit still set, mode bit changed.
- **FREE→IDLE / PERIOD→IDLE:** enable bit cleared.
- **Self-loop:** the state is held when there is no control write.

Top module: `tick_down_timer`

## Requirements
- R1: After reset, the load register and the counter are 0xFFFF, the control register reads 0, and `irq` is low.
- R2: Register map (byte offsets on `bus_addr`):
  - 0x0 is the load register. It is read/write, and only bits 15:0 are stored.
  - 0x4 is the current count. It is read-only, and writes to it have no effect.
  - 0x8 is control.
  - 0xC is interrupt clear. It reads as 0.
  - Bits 31:16 of load and count read as zero.
- R3: A write to offset 0x0 copies bits 15:0 into the counter at the same clock edge and restarts the prescaler from zero. The next decrement therefore comes a full prescale period later.
- R4: Control bit 7 enables counting. While it is 0, the count holds its value.
- R5: Control bits 3:2 choose the divider: 00 divides by 1, 01 by 16, 10 by 256, and 11 by 1. After the counter is loaded or enabled, the first decrement lands on the Nth enabled clock edge, where N is the divisor.
- R6: With control bit 6 at 0 (free-running), a tick at count 0 moves the count to 0xFFFF.
- R7: With control bit 6 at 1 (periodic), a tick at count 0 moves the count to the load register value.
- R8: A tick taken at count 0 sets the expiry flag. `irq` equals the flag ANDed with control bit 5, so the flag is kept while the output is masked.
- R9: A write to offset 0xC clears the expiry flag and drops `irq`.
- R10: While `clk_en` is low, neither the prescaler nor the counter advances.
- R11: Control reads back bits 7, 6, 5, 3 and 2 as last written, and all other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Qualifies which clock edges count toward the prescaler |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, sampled with `bus_sel` on the rising edge |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Masked expiry interrupt, level |

## Verification
The hardest situations to reach from the ports are the edge-exact ones:

- **Divide-by-256 first decrement:** this happens 256 clock edges after enabling, with nothing visible in between.
- **Load write mid-prescale:** this must discard a partly filled prescale count.

The stimulus loads the counter while halted, so the prescaler is known to sit at zero. It then enables the counter and counts edges from the enabling write before it reads the count. For the restart case, it lets the divide-by-16 prescaler fill partway and then rewrites the load register. It then expects the decrement exactly sixteen edges after that write, not at the old boundary.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FREE   = 2'd1,
        ST_PERIOD = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV16  = 2'b01,
        PS_DIV256 = 2'b10,
        PS_RSVD   = 2'b11
    } ps_code_e;

    localparam int unsigned OFS_LOAD   = 0;
    localparam int unsigned OFS_VALUE  = 4;
    localparam int unsigned OFS_CTRL   = 8;
    localparam int unsigned OFS_CLEAR  = 12;

    localparam int unsigned CTRL_EN_BIT   = 7;
    localparam int unsigned CTRL_MODE_BIT = 6;
    localparam int unsigned CTRL_IE_BIT   = 5;
    localparam int unsigned CTRL_PS_LO    = 2;

endpackage

// File: rtl/tick_timer_regs.sv
`timescale 1ns/1ps
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_value,
    output logic              load_wr,
    output logic [CNT_W-1:0]  load_value,
    output logic              clear_wr,
    output logic              run,
    output logic              periodic,
    output logic              irq_en,
    output ps_code_e          ps_code
);

    localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
    localparam logic [ADDR_W-1:0] A_VALUE = ADDR_W'(OFS_VALUE);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] load_q;
    logic             mode_q;
    logic             ie_q;
    logic [1:0]       ps_q;
    logic             wr_hit;
    logic             ctrl_wr;
    logic             want_en;
    logic             want_per;
    logic             wdata_unused;

    assign wr_hit   = bus_sel & bus_wr;
    assign load_wr  = wr_hit && (bus_addr == A_LOAD);
    assign ctrl_wr  = wr_hit && (bus_addr == A_CTRL);
    assign clear_wr = wr_hit && (bus_addr == A_CLEAR);
    assign want_en  = bus_wdata[CTRL_EN_BIT];
    assign want_per = bus_wdata[CTRL_MODE_BIT];
    assign wdata_unused = ^{bus_wdata[DATA_W-1:CNT_W], bus_wdata[4], bus_wdata[1:0]};

    // next-state logic: every transition is a control write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr && want_en)
                    state_d = want_per ? ST_PERIOD : ST_FREE;
            end
            ST_FREE, ST_PERIOD: begin
                if (ctrl_wr)
                    state_d = !want_en ? ST_IDLE :
                              (want_per ? ST_PERIOD : ST_FREE);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // state outputs
    always_comb begin
        run      = 1'b0;
        periodic = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin run = 1'b0; periodic = 1'b0; end
            ST_FREE:   begin run = 1'b1; periodic = 1'b0; end
            ST_PERIOD: begin run = 1'b1; periodic = 1'b1; end
            default:   begin run = 1'b0; periodic = 1'b0; end
        endcase
    end

    // register fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '1;
            mode_q <= 1'b0;
            ie_q   <= 1'b0;
            ps_q   <= 2'b00;
        end else begin
            if (load_wr)
                load_q <= bus_wdata[CNT_W-1:0];
            if (ctrl_wr) begin
                mode_q <= want_per;
                ie_q   <= bus_wdata[CTRL_IE_BIT];
                ps_q   <= bus_wdata[CTRL_PS_LO+1:CTRL_PS_LO];
            end
        end
    end

    assign load_value = load_q;
    assign irq_en     = ie_q;
    assign ps_code    = ps_code_e'(ps_q);

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_LOAD) begin
            bus_rdata = DATA_W'(load_q);
        end else if (bus_addr == A_VALUE) begin
            bus_rdata = DATA_W'(cnt_value);
        end else if (bus_addr == A_CTRL) begin
            bus_rdata[CTRL_EN_BIT]                 = run;
            bus_rdata[CTRL_MODE_BIT]               = mode_q;
            bus_rdata[CTRL_IE_BIT]                 = ie_q;
            bus_rdata[CTRL_PS_LO+1:CTRL_PS_LO]     = ps_q;
        end else if (bus_addr == A_CLEAR) begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/tick_timer_prescale.sv
`timescale 1ns/1ps
module tick_timer_prescale
    import tick_timer_pkg::*;
#(
    parameter int unsigned PS_MID_LOG2 = 4,
    parameter int unsigned PS_HI_LOG2  = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clk_en,
    input  logic     run,
    input  logic     restart,
    input  ps_code_e ps_code,
    output logic     tick
);

    localparam int unsigned PC_W = PS_HI_LOG2;
    localparam logic [PC_W-1:0] LIM_MID = PC_W'((1 << PS_MID_LOG2) - 1);
    localparam logic [PC_W-1:0] LIM_HI  = {PC_W{1'b1}};

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] limit;

    always_comb begin
        unique case (ps_code)
            PS_DIV16:  limit = LIM_MID;
            PS_DIV256: limit = LIM_HI;
            PS_DIV1:   limit = '0;
            PS_RSVD:   limit = '0;
            default:   limit = '0;
        endcase
    end

    // >= so a divider change mid-count never strands the counter
    assign tick = run && clk_en && (pc_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc_q <= '0;
        else if (restart || !run)
            pc_q <= '0;
        else if (clk_en)
            pc_q <= tick ? '0 : pc_q + 1'b1;
    end

endmodule

// File: rtl/tick_timer_counter.sv
`timescale 1ns/1ps
module tick_timer_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_wdata,
    input  logic [CNT_W-1:0] load_value,
    input  logic             periodic,
    input  logic             clear_wr,
    output logic [CNT_W-1:0] cnt_value,
    output logic             expire_flag
);

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             at_zero;
    logic             expire;

    assign at_zero = (cnt_q == '0);
    assign expire  = tick && at_zero && !load_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '1;
        else if (load_wr)
            cnt_q <= load_wdata;
        else if (tick)
            cnt_q <= at_zero ? (periodic ? load_value : '1) : cnt_q - 1'b1;
    end

    // expiry sets, clear drops; a coincident expiry wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (expire)
            flag_q <= 1'b1;
        else if (clear_wr)
            flag_q <= 1'b0;
    end

    assign cnt_value   = cnt_q;
    assign expire_flag = flag_q;

endmodule

// File: rtl/tick_down_timer.sv
`timescale 1ns/1ps
module tick_down_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned PS_MID_LOG2 = 4,
    parameter int unsigned PS_HI_LOG2  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic             load_wr;
    logic             clear_wr;
    logic [CNT_W-1:0] load_value;
    logic [CNT_W-1:0] cnt_value;
    logic             run;
    logic             periodic;
    logic             irq_en;
    logic             pre_tick;
    logic             exp_flag;
    ps_code_e         ps_code;

    tick_timer_regs #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt_value  (cnt_value),
        .load_wr    (load_wr),
        .load_value (load_value),
        .clear_wr   (clear_wr),
        .run        (run),
        .periodic   (periodic),
        .irq_en     (irq_en),
        .ps_code    (ps_code)
    );

    tick_timer_prescale #(
        .PS_MID_LOG2 (PS_MID_LOG2),
        .PS_HI_LOG2  (PS_HI_LOG2)
    ) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .run     (run),
        .restart (load_wr),
        .ps_code (ps_code),
        .tick    (pre_tick)
    );

    tick_timer_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (pre_tick),
        .load_wr     (load_wr),
        .load_wdata  (bus_wdata[CNT_W-1:0]),
        .load_value  (load_value),
        .periodic    (periodic),
        .clear_wr    (clear_wr),
        .cnt_value   (cnt_value),
        .expire_flag (exp_flag)
    );

    assign irq = exp_flag & irq_en;

endmodule

// File: rtl/tick_timer_chk.sv
`timescale 1ns/1ps
module tick_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             load_wr,
    input logic [CNT_W-1:0] load_data,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load_value,
    input logic             periodic,
    input logic             run,
    input logic             flag,
    input logic             clear_wr
);

    // R10
    no_clk_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !load_wr) |=> $stable(cnt));

    // R4
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_wr) |=> $stable(cnt));

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (cnt == $past(load_data)));

    // R6
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && !load_wr && cnt == '0) |=> (cnt == '0 || cnt == '1));

    // R7
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periodic && !load_wr && cnt == '0) |=> (cnt == '0 || cnt == $past(load_value)));

    // R8
    flag_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(cnt) == '0));

    // R9
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_wr && cnt != '0) |=> !flag);

endmodule

bind tick_down_timer tick_timer_chk #(.CNT_W(CNT_W)) i_tick_timer_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .load_wr    (load_wr),
    .load_data  (bus_wdata[CNT_W-1:0]),
    .cnt        (cnt_value),
    .load_value (load_value),
    .periodic   (periodic),
    .run        (run),
    .flag       (exp_flag),
    .clear_wr   (clear_wr)
);

// File: tb/test_tick_down_timer.sv
`timescale 1ns/100ps
module test_tick_down_timer;

    typedef struct {
        logic        is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t exp_q[$];

    always #4 clk = ~clk;

    tick_down_timer i_tick_down_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // driver side: queue expected results
    task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        exp_q.push_back('{1'b0, e, tag});
        #0.5;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        exp_q.push_back('{1'b1, {31'b0, e}, tag});
        #0.5;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop and compare
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            #0.2;
            begin
                item_t it;
                logic [31:0] act;
                it = exp_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(4'h0, 32'h0000_FFFF, "R1 load reset");
        rd_chk(4'h4, 32'h0000_FFFF, "R1 count reset");
        rd_chk(4'h8, 32'h0, "R1 ctrl reset");
        irq_chk(1'b0, "R1 irq reset");
        rd_chk(4'hC, 32'h0, "R2 clear reads zero");

        // R2 / R3 load while halted, upper bits dropped
        wr(4'h0, 32'hABCD_1234);
        rd_chk(4'h0, 32'h0000_1234, "R2 load upper zero");
        rd_chk(4'h4, 32'h0000_1234, "R3 load copies count");
        wr(4'h4, 32'h0000_0055);
        rd_chk(4'h4, 32'h0000_1234, "R2 count write ignored");
        step(3);
        rd_chk(4'h4, 32'h0000_1234, "R4 halted holds");

        // free-running divide by 1
        wr(4'h0, 32'd5);
        wr(4'h8, 32'h80);
        rd_chk(4'h8, 32'h80, "R11 ctrl readback");
        rd_chk(4'h4, 32'd5, "R5 no tick yet");
        step(1);
        rd_chk(4'h4, 32'd4, "R5 div1 first edge");
        step(4);
        rd_chk(4'h4, 32'd0, "R5 reaches zero");
        step(1);
        rd_chk(4'h4, 32'h0000_FFFF, "R6 free wrap");
        irq_chk(1'b0, "R8 masked");
        wr(4'h8, 32'hA0);
        irq_chk(1'b1, "R8 flag kept while masked");
        rd_chk(4'h8, 32'hA0, "R11 ctrl ie readback");
        wr(4'hC, 32'h0);
        irq_chk(1'b0, "R9 clear drops irq");

        // periodic divide by 1
        wr(4'h8, 32'h00);
        wr(4'h0, 32'd3);
        wr(4'h8, 32'hE0);
        rd_chk(4'h4, 32'd3, "R7 start");
        step(3);
        rd_chk(4'h4, 32'd0, "R7 at zero");
        irq_chk(1'b0, "R8 no irq before expiry");
        step(1);
        rd_chk(4'h4, 32'd3, "R7 reload");
        irq_chk(1'b1, "R8 irq on expiry");
        step(1);
        rd_chk(4'h4, 32'd2, "R7 counts after reload");
        wr(4'h8, 32'hFFFF_FF7F);
        rd_chk(4'h8, 32'h0000_006C, "R11 undefined bits zero");
        rd_chk(4'h4, 32'd1, "R4 last tick before halt");
        step(4);
        rd_chk(4'h4, 32'd1, "R4 disabled holds");
        wr(4'hC, 32'h0);

        // divide by 16
        wr(4'h0, 32'd2);
        wr(4'h8, 32'h84);
        step(15);
        rd_chk(4'h4, 32'd2, "R5 div16 edge 15");
        step(1);
        rd_chk(4'h4, 32'd1, "R5 div16 edge 16");
        step(5);
        wr(4'h0, 32'd7);
        rd_chk(4'h4, 32'd7, "R3 load while running");
        step(15);
        rd_chk(4'h4, 32'd7, "R3 prescaler restarted");
        step(1);
        rd_chk(4'h4, 32'd6, "R3 decrement after full period");

        // divide by 256
        wr(4'h8, 32'h00);
        wr(4'h0, 32'h0000_FFFF);
        wr(4'h8, 32'h88);
        rd_chk(4'h8, 32'h88, "R11 div256 readback");
        step(255);
        rd_chk(4'h4, 32'h0000_FFFF, "R5 div256 edge 255");
        step(1);
        rd_chk(4'h4, 32'h0000_FFFE, "R5 div256 edge 256");

        // reserved code acts as divide by 1, then clk_en gating
        wr(4'h8, 32'h00);
        wr(4'h0, 32'd10);
        wr(4'h8, 32'h8C);
        step(1);
        rd_chk(4'h4, 32'd9, "R5 reserved is div1");
        clk_en = 1'b0;
        step(5);
        rd_chk(4'h4, 32'd9, "R10 clk_en low freezes");
        clk_en = 1'b1;
        step(1);
        rd_chk(4'h4, 32'd8, "R10 resumes");

        #1;
        wait (exp_q.size() == 0);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule